// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of an 8051-style core and turns push and pop requests into accesses on a stack RAM. In the narrow mode it keeps an 8-bit pointer that addresses the 256-byte internal data RAM. When the wide-stack control bit is set, it joins a 2-bit field held in a separate extension register to the 8-bit pointer. The resulting 10-bit pointer addresses a 1 KB window of the extended on-chip RAM. Carries out of the pointer on a push, and borrows into it on a pop, move that field.

The core issues one-cycle strobes. A push moves the pointer up first and then writes at the new location. A pop reads at the current location and then moves the pointer down. The block drives the RAM address, a bank select, a write enable, a read enable and the write data in the cycle of the strobe. It expects a synchronous-read RAM and forwards that RAM's output as the popped byte, flagged valid, one cycle after the pop strobe. The pointer and the extension register can be read and written as special function registers.

Top module: `stk_ptr`

## Requirements
- R1: After reset the pointer reads 0x07, the extension register reads 0xFC and `pop_valid` is 0.
- R2: In narrow mode (`wide_mode`=0) a push increments the pointer modulo 256 and writes the push data at the new pointer value. Wrapping from 0xFF to 0x00 leaves the extension register unchanged.
- R3: A pop reads at the current pointer and then decrements it. The byte stored there appears on `pop_data`, with `pop_valid`=1, in the cycle after the strobe. The popped order is last in, first out.
- R4: In wide mode (`wide_mode`=1) the RAM address is field*256 + pointer and `mem_sel`=1 (extended RAM). In narrow mode `mem_sel`=0 (internal RAM).
- R5: In wide mode a push with the pointer at 0xFF sets the pointer to 0x00 and increments the field modulo 4, so 3 becomes 0.
- R6: In wide mode a pop with the pointer at 0x00 sets the pointer to 0xFF and decrements the field modulo 4, so 0 becomes 3.
- R7: Only bits 1:0 of the extension register are stored. Bits 7:2 always read back as ones.
- R8: In narrow mode the field takes no part in addressing: `mem_addr` bits 9:8 are 0 whatever the field holds.
- R9: A register write with `sfr_we`=1 takes effect on the next clock edge. With `sfr_sel`=0 it loads the pointer; with `sfr_sel`=1 it loads the field.
- R10: A register write in the same cycle as a push or a pop is dropped. The stack operation alone updates the pointer and the field.
- R11: A push and a pop in the same cycle perform the push only. No read is issued, the pointer does not decrement, and `pop_valid` stays 0.
- R12: `mem_we` is high only in a cycle that performs a push, and `mem_re` only in a cycle that performs a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | Wide-stack enable, taken from bit 2 of the address-control register |
| push_req | input | 1 | Push strobe |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop strobe |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 1 | Register select: 0 pointer, 1 extension |
| sfr_wdata | input | 8 | Register write data |
| sp_q | output | 8 | Pointer read-back |
| ext_q | output | 8 | Extension register read-back |
| mem_addr | output | 10 | Stack RAM address |
| mem_sel | output | 1 | RAM bank: 0 internal, 1 extended |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_re` |
| pop_valid | output | 1 | Popped byte valid |
| pop_data | output | 8 | Popped byte |

## Verification
Two collisions can occur in one cycle. The first is a register write arriving together with a push or a pop. The second is a push arriving together with a pop. The bench drives a pointer write of 0x40 beside a push, and an extension write beside a pop. It then requires the pointer and field to equal the single-step result and the popped byte to be correct. For the push-and-pop case it checks that the pointer went up by one, that the pushed byte landed in the RAM model, and that no valid pop follows.

// File: rtl/stk_pkg.sv
package stk_pkg;
  // Operation chosen for a cycle after arbitration
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/stk_arb.sv
module stk_arb
  import stk_pkg::*;
(
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    sfr_we,
  output stk_op_e op,
  output logic    sfr_take
);
  // Push outranks pop; register writes yield to any stack operation
  always_comb begin
    if (push_req)     op = OP_PUSH;
    else if (pop_req) op = OP_POP;
    else              op = OP_NONE;
    sfr_take = sfr_we && (op == OP_NONE);
  end
endmodule

// File: rtl/stk_step.sv
module stk_step
  import stk_pkg::*;
#(
  parameter int SP_W  = 8,
  parameter int FLD_W = 2
) (
  input  stk_op_e          op,
  input  logic             wide,
  input  logic [SP_W-1:0]  sp_cur,
  input  logic [FLD_W-1:0] fld_cur,
  output logic [SP_W-1:0]  sp_nxt,
  output logic [FLD_W-1:0] fld_nxt
);
  localparam logic [SP_W-1:0]  SP_ONE  = SP_W'(1);
  localparam logic [SP_W-1:0]  SP_TOP  = '1;
  localparam logic [SP_W-1:0]  SP_BOT  = '0;
  localparam logic [FLD_W-1:0] FLD_ONE = FLD_W'(1);

  always_comb begin
    sp_nxt  = sp_cur;
    fld_nxt = fld_cur;
    case (op)
      OP_PUSH: begin
        sp_nxt = sp_cur + SP_ONE;
        if (wide && sp_cur == SP_TOP) fld_nxt = fld_cur + FLD_ONE;
      end
      OP_POP: begin
        sp_nxt = sp_cur - SP_ONE;
        if (wide && sp_cur == SP_BOT) fld_nxt = fld_cur - FLD_ONE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_addr.sv
module stk_addr
  import stk_pkg::*;
#(
  parameter int SP_W  = 8,
  parameter int FLD_W = 2,
  localparam int ADDR_W = SP_W + FLD_W
) (
  input  stk_op_e           op,
  input  logic              wide,
  input  logic [SP_W-1:0]   sp_cur,
  input  logic [FLD_W-1:0]  fld_cur,
  input  logic [SP_W-1:0]   sp_nxt,
  input  logic [FLD_W-1:0]  fld_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel,
  output logic              mem_we,
  output logic              mem_re
);
  logic [SP_W-1:0]  sp_pick;
  logic [FLD_W-1:0] fld_pick;

  // Push addresses the incremented pointer, pop the current one
  always_comb begin
    if (op == OP_PUSH) begin
      sp_pick  = sp_nxt;
      fld_pick = fld_nxt;
    end else begin
      sp_pick  = sp_cur;
      fld_pick = fld_cur;
    end
    mem_addr = wide ? {fld_pick, sp_pick} : {{FLD_W{1'b0}}, sp_pick};
    mem_sel  = wide;
    mem_we   = (op == OP_PUSH);
    mem_re   = (op == OP_POP);
  end
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          FLD_W   = 2,
  parameter logic [7:0]  SP_RST  = 8'h07,
  parameter logic [7:0]  EXT_RST = 8'hFC,
  localparam int SP_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [SP_W-1:0]   sp_nxt,
  input  logic [FLD_W-1:0]  fld_nxt,
  input  logic              sfr_take,
  input  logic              sfr_sel,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [SP_W-1:0]   sp_r,
  output logic [FLD_W-1:0]  fld_r,
  output logic [DATA_W-1:0] ext_q,
  output logic              pop_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_r      <= SP_W'(SP_RST);
      fld_r     <= EXT_RST[FLD_W-1:0];
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= (op == OP_POP);
      if (op != OP_NONE) begin
        sp_r  <= sp_nxt;
        fld_r <= fld_nxt;
      end else if (sfr_take) begin
        if (sfr_sel) fld_r <= sfr_wdata[FLD_W-1:0];
        else         sp_r  <= sfr_wdata;
      end
    end
  end

  // Unused upper extension bits read back as ones
  generate
    if (DATA_W > FLD_W) begin : g_pad
      assign ext_q = {{(DATA_W-FLD_W){1'b1}}, fld_r};
    end else begin : g_nopad
      assign ext_q = fld_r[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         FLD_W   = 2,
  parameter logic [7:0] SP_RST  = 8'h07,
  parameter logic [7:0] EXT_RST = 8'hFC,
  localparam int SP_W   = DATA_W,
  localparam int ADDR_W = SP_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              sfr_we,
  input  logic              sfr_sel,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [SP_W-1:0]   sp_q,
  output logic [DATA_W-1:0] ext_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data
);
  stk_op_e          op;
  logic             sfr_take;
  logic [SP_W-1:0]  sp_r, sp_nxt;
  logic [FLD_W-1:0] fld_r, fld_nxt;

  stk_arb u_arb (
    .push_req (push_req),
    .pop_req  (pop_req),
    .sfr_we   (sfr_we),
    .op       (op),
    .sfr_take (sfr_take)
  );

  stk_step #(.SP_W(SP_W), .FLD_W(FLD_W)) u_step (
    .op      (op),
    .wide    (wide_mode),
    .sp_cur  (sp_r),
    .fld_cur (fld_r),
    .sp_nxt  (sp_nxt),
    .fld_nxt (fld_nxt)
  );

  stk_addr #(.SP_W(SP_W), .FLD_W(FLD_W)) u_addr (
    .op       (op),
    .wide     (wide_mode),
    .sp_cur   (sp_r),
    .fld_cur  (fld_r),
    .sp_nxt   (sp_nxt),
    .fld_nxt  (fld_nxt),
    .mem_addr (mem_addr),
    .mem_sel  (mem_sel),
    .mem_we   (mem_we),
    .mem_re   (mem_re)
  );

  stk_regs #(
    .DATA_W(DATA_W), .FLD_W(FLD_W), .SP_RST(SP_RST), .EXT_RST(EXT_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .sp_nxt    (sp_nxt),
    .fld_nxt   (fld_nxt),
    .sfr_take  (sfr_take),
    .sfr_sel   (sfr_sel),
    .sfr_wdata (sfr_wdata),
    .sp_r      (sp_r),
    .fld_r     (fld_r),
    .ext_q     (ext_q),
    .pop_valid (pop_valid)
  );

  assign sp_q      = sp_r;
  assign mem_wdata = push_data;
  assign pop_data  = pop_valid ? mem_rdata : '0;
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int DATA_W = 8,
  parameter int FLD_W  = 2,
  localparam int SP_W   = DATA_W,
  localparam int ADDR_W = SP_W + FLD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              push_req,
  input logic              pop_req,
  input logic              sfr_we,
  input logic              sfr_sel,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [SP_W-1:0]   sp_q,
  input logic [DATA_W-1:0] ext_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel,
  input logic              mem_we,
  input logic              mem_re,
  input logic              pop_valid
);
  localparam logic [SP_W-1:0]  SP_ONE  = SP_W'(1);
  localparam logic [FLD_W-1:0] FLD_ONE = FLD_W'(1);
  logic [FLD_W-1:0] fld;
  assign fld = ext_q[FLD_W-1:0];

  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    push_req && !wide_mode |=> (sp_q - $past(sp_q)) == SP_ONE && ext_q == $past(ext_q));

  p_pop_valid_r3: assert property (@(posedge clk) disable iff (rst)
    pop_req && !push_req |=> pop_valid);

  p_no_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !(pop_req && !push_req) |=> !pop_valid);

  p_carry_r5: assert property (@(posedge clk) disable iff (rst)
    push_req && wide_mode && sp_q == '1 |=> sp_q == '0 && (fld - $past(fld)) == FLD_ONE);

  p_borrow_r6: assert property (@(posedge clk) disable iff (rst)
    pop_req && !push_req && wide_mode && sp_q == '0 |=> sp_q == '1 && ($past(fld) - fld) == FLD_ONE);

  p_narrow_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (push_req || pop_req) && !wide_mode |-> !mem_sel && mem_addr[ADDR_W-1:SP_W] == '0);

  p_sfr_load_r9: assert property (@(posedge clk) disable iff (rst)
    sfr_we && !push_req && !pop_req && !sfr_sel |=> sp_q == $past(sfr_wdata));

  p_we_push_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> push_req);

  p_re_pop_r12: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> pop_req && !push_req);
endmodule

bind stk_ptr stk_chk #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wide_mode (wide_mode),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .sfr_we    (sfr_we),
  .sfr_sel   (sfr_sel),
  .sfr_wdata (sfr_wdata),
  .sp_q      (sp_q),
  .ext_q     (ext_q),
  .mem_addr  (mem_addr),
  .mem_sel   (mem_sel),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .pop_valid (pop_valid)
);

// File: tb/sim_stk_ptr.sv
`timescale 1ns/1ps
module sim_stk_ptr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wide_mode = 1'b0;
  logic       push_req = 1'b0, pop_req = 1'b0, sfr_we = 1'b0, sfr_sel = 1'b0;
  logic [7:0] push_data = '0, sfr_wdata = '0;
  logic [7:0] sp_q, ext_q, mem_wdata, mem_rdata, pop_data;
  logic [9:0] mem_addr;
  logic       mem_sel, mem_we, mem_re, pop_valid;

  logic [7:0] iram [256];
  logic [7:0] xram [1024];
  logic [7:0] rdq = '0;
  int nchk = 0, nerr = 0;
  int p;

  always #4 clk = ~clk;

  stk_ptr u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .push_req(push_req),
    .push_data(push_data), .pop_req(pop_req), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
    .sfr_wdata(sfr_wdata), .sp_q(sp_q), .ext_q(ext_q), .mem_addr(mem_addr),
    .mem_sel(mem_sel), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pop_valid(pop_valid), .pop_data(pop_data)
  );

  // Synchronous-read RAM models for both banks
  always_ff @(posedge clk) begin
    if (mem_we) begin
      if (mem_sel) xram[mem_addr] <= mem_wdata;
      else         iram[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_re) rdq <= mem_sel ? xram[mem_addr] : iram[mem_addr[7:0]];
  end
  assign mem_rdata = rdq;

  function automatic int dval(input int i);
    return (i * 5 + (i >> 8) * 37 + 17) & 255;
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  // One clock with the given strobes; returns at the following falling edge
  task automatic cyc(input logic ps, input logic pp, input logic [7:0] d,
                     input logic we, input logic sel, input logic [7:0] wd);
    push_req = ps; pop_req = pp; push_data = d;
    sfr_we = we; sfr_sel = sel; sfr_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0; sfr_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset sp", sp_q, 'h07);
    chk("R1 reset ext", ext_q, 'hFC);
    chk("R1 reset valid", pop_valid, 0);

    // R2 narrow sweep: 256 pushes, wrapping once
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b0, 8'((i * 7 + 3) & 255), 1'b0, 1'b0, 8'h00);
      chk("R2 push sp", sp_q, (8 + i) & 255);
      chk("R2 ext unchanged", ext_q, 'hFC);
    end
    // R3 narrow pops in LIFO order
    for (int j = 0; j < 256; j++) begin
      cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R3 valid", pop_valid, 1);
      chk("R3 data", pop_data, ((255 - j) * 7 + 3) & 255);
      chk("R3 sp", sp_q, (6 - j) & 255);
    end
    // R12 idle cycle
    #1;
    chk("R12 idle we", mem_we, 0);
    chk("R12 idle re", mem_re, 0);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R3 valid drops", pop_valid, 0);

    // R9 register loads
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h02);
    chk("R9 ext load", ext_q, 'hFE);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFD);
    chk("R9 sp load", sp_q, 'hFD);

    // Wide sweep over the full 1 KB window
    wide_mode = 1'b1;
    p = 'h2FD;
    for (int i = 0; i < 1024; i++) begin
      cyc(1'b1, 1'b0, 8'(dval(i)), 1'b0, 1'b0, 8'h00);
      p = (p + 1) & 1023;
      chk("R5 wide push sp", sp_q, p & 255);
      chk("R5 wide push ext", ext_q, 'hFC | (p >> 8));
    end
    for (int k = 0; k < 1024; k++)
      chk("R4 extended bank content", xram[(('h2FE + k) & 1023)], dval(k));
    for (int j = 0; j < 1024; j++) begin
      cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R6 wide pop data", pop_data, dval(1023 - j));
      p = (p - 1) & 1023;
      chk("R6 wide pop sp", sp_q, p & 255);
      chk("R6 wide pop ext", ext_q, 'hFC | (p >> 8));
    end

    // R8 narrow push with field = 2
    wide_mode = 1'b0;
    push_req = 1'b1; push_data = 8'hA5;
    #1;
    chk("R8 addr", mem_addr, 'h0FE);
    chk("R8 sel", mem_sel, 0);
    chk("R12 we on push", mem_we, 1);
    @(posedge clk); @(negedge clk);
    push_req = 1'b0;
    chk("R8 internal write", iram[8'hFE], 'hA5);
    chk("R8 ext unchanged", ext_q, 'hFE);
    chk("R8 sp", sp_q, 'hFE);

    // R4 wide pop address
    wide_mode = 1'b1;
    pop_req = 1'b1;
    #1;
    chk("R4 addr", mem_addr, 'h2FE);
    chk("R4 sel", mem_sel, 1);
    chk("R12 re on pop", mem_re, 1);
    @(posedge clk); @(negedge clk);
    pop_req = 1'b0;
    chk("R4 pop data", pop_data, dval(0));
    chk("R4 sp", sp_q, 'hFD);

    // R10 register write colliding with push, then with pop
    cyc(1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h40);
    chk("R10 push wins sp", sp_q, 'hFE);
    cyc(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00);
    chk("R10 pop wins sp", sp_q, 'hFD);
    chk("R10 pop wins ext", ext_q, 'hFE);
    chk("R10 pop data", pop_data, 'h3C);

    // R11 push and pop together
    cyc(1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 8'h00);
    chk("R11 sp", sp_q, 'hFE);
    chk("R11 no valid", pop_valid, 0);
    chk("R11 written", xram[10'h2FE], 'h77);

    // R5/R6 field wrap 3 <-> 0, R7 readback
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF);
    chk("R7 ext ff", ext_q, 'hFF);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF);
    cyc(1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 8'h00);
    chk("R5 wrap sp", sp_q, 'h00);
    chk("R5 wrap ext", ext_q, 'hFC);
    chk("R5 wrap write", xram[10'h000], 'h99);
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R6 wrap sp", sp_q, 'hFF);
    chk("R6 wrap ext", ext_q, 'hFF);
    chk("R6 wrap data", pop_data, 'h99);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01);
    chk("R7 ext 01", ext_q, 'hFD);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00);
    chk("R7 ext 00", ext_q, 'hFC);

    finish_run();
  end
endmodule